// File: doc/BRIEF.md
# AES Round-Key Schedule Generator

This block turns an AES cipher key of 128, 192 or 256 bits into the complete set of round keys, and keeps the result in a banked on-chip store. It reads the cipher key in 64-bit pieces. It then produces two new 32-bit schedule words on every clock until the whole schedule exists: 44, 52 or 60 words. The RotWord, SubWord and round-constant steps are applied at the points the AES expansion places them. The S-box used by SubWord is computed with finite-field arithmetic rather than held as a table.

Each expansion targets one bank of a 64-bit-wide store. The key words and the generated words are written into that bank in ascending order, one word pair per entry. A separate read port takes a bank number and a round number and returns that round's 128-bit key one cycle later, for use by a cipher datapath. Several banks can hold schedules for different keys at once. Generation only runs forward, as a precompute step before the cipher uses the keys.

Top module: `aes_key_expander`

## Requirements
- R1: The key length is chosen by `keyLen` when `start` is accepted: code 0 selects 128 bits (Nk=4, 44 words), code 1 selects 192 bits (Nk=6, 52 words), code 2 selects 256 bits (Nk=8, 60 words).
- R2: After an accepted start, the block takes Nk/2 key pieces, one on each clock where `keyValid` is high, and skips clocks where it is low. In each piece, bits 63:32 hold the lower-numbered key word and bits 31:0 the next word.
- R3: The stored schedule equals the AES key expansion. w[i] = w[i-Nk] xor temp. temp is w[i-1], replaced by SubWord(RotWord(w[i-1])) xor (Rcon << 24) when i mod Nk = 0, and by SubWord(w[i-1]) when Nk=8 and i mod 8 = 4. Rcon starts at 0x01 and is doubled in GF(2^8) with 0x1B reduction after each use.
- R4: Once the key is loaded, two words are generated per clock. With no idle key clocks, `busy` stays high for Nk/2 + (total words - Nk)/2 clocks after the start edge: 22, 26 or 30.
- R5: Bank b, entry j holds {w[2j], w[2j+1]}. One cycle after `rdBank`/`rdRound` are presented, `rdKey` returns {w[4r], w[4r+1], w[4r+2], w[4r+3]} of round r, with w[4r] in bits 127:96.
- R6: An expansion writes only its own bank; every other bank keeps its contents.
- R7: A `start` while `busy` is high is ignored; the running expansion's length, bank and results are unchanged.
- R8: After reset, `busy` and `done` are low. `done` is low while `busy` is high, rises in the clock after the last word pair is written, and stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new expansion (taken only when idle) |
| keyLen | input | 2 | Key length code: 0=128, 1=192, 2=256 |
| bankSel | input | log2(NumBanks) (3) | Target bank for the expansion |
| keyValid | input | 1 | keyWord carries the next key piece |
| keyWord | input | 64 | Two cipher-key words, lower index in the upper half |
| busy | output | 1 | Key loading or expansion in progress |
| done | output | 1 | Last expansion is complete |
| rdBank | input | log2(NumBanks) (3) | Bank to read |
| rdRound | input | 4 | Round index to read (0..Nr) |
| rdKey | output | 128 | Round key, valid one cycle after the address |

## Verification
The hardest situation to reach is a 256-bit expansion whose cycles alternate between the full RotWord/Rcon step and the SubWord-only step. In those cycles the second word of a pair depends on the transformed first word. The bench runs all three key lengths with the standard example keys and with patterned keys, and compares every round of every bank with a schedule it computes from an S-box that it builds by generator iteration. It also drives an idle key clock during loading, and fires a start aimed at a pre-filled bank in the middle of an expansion. It then rereads that bank to show that the start had no effect.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  localparam int MaxWords  = 60;
  localparam int EntryBits = $clog2(MaxWords / 2);
  localparam int RoundBits = EntryBits - 1;

  typedef enum logic [1:0] {
    KL128 = 2'd0,
    KL192 = 2'd1,
    KL256 = 2'd2
  } keyLenT;

  typedef struct packed {
    logic loadShift;
    logic genShift;
    logic doRot;
    logic doSubOnly;
    logic rconInit;
  } ksStrobeT;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = xtime(aa);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254, zero maps to zero
  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = x;
    for (int k = 1; k < 8; k++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] b;
    b = ginv(x);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^
           {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] subWord(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

endpackage

// File: rtl/aes_ks_ctrl.sv
module aes_ks_ctrl
  import aes_ks_pkg::*;
#(
  parameter int BankBits = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [1:0]                    keyLen,
  input  logic [BankBits-1:0]           bankSel,
  input  logic                          keyValid,
  output ksStrobeT                      strobe,
  output logic [1:0]                    lenQ,
  output logic [BankBits+EntryBits-1:0] wrAddr,
  output logic                          busy,
  output logic                          done
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_EXPAND} stateT;

  stateT                state;
  logic [BankBits-1:0]  bankQ;
  logic [EntryBits-1:0] entry;
  logic [2:0]           modCnt;
  logic [2:0]           nkHalfM1;
  logic [EntryBits-1:0] lastEntry;
  logic [2:0]           modWrap;

  always_comb begin
    unique case (lenQ)
      KL192:   begin nkHalfM1 = 3'd2; lastEntry = EntryBits'(25); modWrap = 3'd4; end
      KL256:   begin nkHalfM1 = 3'd3; lastEntry = EntryBits'(29); modWrap = 3'd6; end
      default: begin nkHalfM1 = 3'd1; lastEntry = EntryBits'(21); modWrap = 3'd2; end
    endcase
  end

  assign busy   = (state != S_IDLE);
  assign wrAddr = {bankQ, entry};

  always_comb begin
    strobe           = '0;
    strobe.loadShift = (state == S_LOAD) && keyValid;
    strobe.genShift  = (state == S_EXPAND);
    strobe.doRot     = (state == S_EXPAND) && (modCnt == 3'd0);
    strobe.doSubOnly = (state == S_EXPAND) && (lenQ == KL256) && (modCnt == 3'd4);
    strobe.rconInit  = (state == S_IDLE) && start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      lenQ   <= 2'd0;
      bankQ  <= '0;
      entry  <= '0;
      modCnt <= 3'd0;
      done   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_LOAD;
            lenQ  <= (keyLen == 2'd3) ? 2'd0 : keyLen;
            bankQ <= bankSel;
            entry <= '0;
            done  <= 1'b0;
          end
        end
        S_LOAD: begin
          if (keyValid) begin
            entry <= entry + 1'b1;
            if (entry == EntryBits'(nkHalfM1)) begin
              state  <= S_EXPAND;
              modCnt <= 3'd0;
            end
          end
        end
        S_EXPAND: begin
          entry  <= entry + 1'b1;
          modCnt <= (modCnt == modWrap) ? 3'd0 : modCnt + 3'd2;
          if (entry == lastEntry) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aes_ks_datapath.sv
module aes_ks_datapath
  import aes_ks_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ksStrobeT    strobe,
  input  logic [1:0]  lenQ,
  input  logic [63:0] keyWord,
  output logic [63:0] wrData
);

  localparam int Window = 8;

  logic [31:0] hist [Window];
  logic [7:0]  rcon;
  logic [31:0] backA;
  logic [31:0] backB;
  logic [31:0] sIn;
  logic [31:0] sOut;
  logic [31:0] temp;
  logic [31:0] newA;
  logic [31:0] newB;

  // word i-Nk and i+1-Nk sit at window slots 8-Nk and 9-Nk
  always_comb begin
    unique case (lenQ)
      KL192:   begin backA = hist[2]; backB = hist[3]; end
      KL256:   begin backA = hist[0]; backB = hist[1]; end
      default: begin backA = hist[4]; backB = hist[5]; end
    endcase
  end

  assign sIn  = strobe.doRot ? {hist[Window-1][23:0], hist[Window-1][31:24]}
                             : hist[Window-1];
  assign sOut = subWord(sIn);

  always_comb begin
    if (strobe.doRot)          temp = sOut ^ {rcon, 24'h000000};
    else if (strobe.doSubOnly) temp = sOut;
    else                       temp = hist[Window-1];
  end

  // pair index is even, so the second word never needs a transform
  assign newA   = backA ^ temp;
  assign newB   = backB ^ newA;
  assign wrData = strobe.loadShift ? keyWord : {newA, newB};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < Window; i++) hist[i] <= '0;
      rcon <= 8'h01;
    end else begin
      if (strobe.loadShift || strobe.genShift) begin
        for (int i = 0; i < Window - 2; i++) hist[i] <= hist[i+2];
        hist[Window-2] <= wrData[63:32];
        hist[Window-1] <= wrData[31:0];
      end
      if (strobe.rconInit)   rcon <= 8'h01;
      else if (strobe.doRot) rcon <= xtime(rcon);
    end
  end

endmodule

// File: rtl/aes_ks_ram.sv
module aes_ks_ram #(
  parameter int AddrBits = 8,
  parameter int DataBits = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [AddrBits-1:0]   wrAddr,
  input  logic [DataBits-1:0]   wrData,
  input  logic [AddrBits-2:0]   rdPair,
  output logic [2*DataBits-1:0] rdData
);

  localparam int Depth = 1 << AddrBits;

  logic [DataBits-1:0] mem [Depth];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= {mem[{rdPair, 1'b0}], mem[{rdPair, 1'b1}]};
  end

endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander
  import aes_ks_pkg::*;
#(
  parameter int NumBanks = 8,
  localparam int BankBits = $clog2(NumBanks)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [1:0]           keyLen,
  input  logic [BankBits-1:0]  bankSel,
  input  logic                 keyValid,
  input  logic [63:0]          keyWord,
  output logic                 busy,
  output logic                 done,
  input  logic [BankBits-1:0]  rdBank,
  input  logic [RoundBits-1:0] rdRound,
  output logic [127:0]         rdKey
);

  localparam int AddrBits = BankBits + EntryBits;

  ksStrobeT            strobe;
  logic [1:0]          lenQ;
  logic [AddrBits-1:0] wrAddr;
  logic [63:0]         wrData;
  logic                ramWrEn;

  assign ramWrEn = strobe.loadShift | strobe.genShift;

  aes_ks_ctrl #(.BankBits(BankBits)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .keyLen(keyLen), .bankSel(bankSel),
    .keyValid(keyValid), .strobe(strobe), .lenQ(lenQ), .wrAddr(wrAddr),
    .busy(busy), .done(done)
  );

  aes_ks_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lenQ(lenQ),
    .keyWord(keyWord), .wrData(wrData)
  );

  aes_ks_ram #(.AddrBits(AddrBits), .DataBits(64)) u_ram (
    .clk(clk), .rstN(rstN), .wrEn(ramWrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdPair({rdBank, rdRound}), .rdData(rdKey)
  );

endmodule

// File: rtl/aes_ks_checker.sv
module aes_ks_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [1:0] keyLen,
  input logic       busy,
  input logic       done,
  input logic       wrEn
);

  logic [1:0] lenSeen;
  logic [5:0] wrCount;
  logic [5:0] wantEntries;

  always_comb begin
    unique case (lenSeen)
      2'd1:    wantEntries = 6'd26;
      2'd2:    wantEntries = 6'd30;
      default: wantEntries = 6'd22;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenSeen <= 2'd0;
      wrCount <= '0;
    end else if (start && !busy) begin
      lenSeen <= (keyLen == 2'd3) ? 2'd0 : keyLen;
      wrCount <= '0;
    end else if (wrEn) begin
      wrCount <= wrCount + 1'b1;
    end
  end

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_start_taken_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_end_sets_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_done_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_write_when_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  assert_schedule_length_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (wrCount == wantEntries));

endmodule

bind aes_key_expander aes_ks_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .keyLen(keyLen),
  .busy(busy), .done(done), .wrEn(ramWrEn)
);

// File: tb/tb_aes_key_expander.sv
module tb_aes_key_expander;

  localparam int ClkPeriod = 10;
  localparam int Banks = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   keyLen = 2'd0;
  logic [2:0]   bankSel = 3'd0;
  logic         keyValid = 1'b0;
  logic [63:0]  keyWord = '0;
  logic         busy;
  logic         done;
  logic [2:0]   rdBank = 3'd0;
  logic [3:0]   rdRound = 4'd0;
  logic [127:0] rdKey;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0]  sb [256];
  logic [31:0] bm [Banks][60];
  int          bankLen [Banks];

  always #(ClkPeriod/2) clk = ~clk;
  always @(posedge clk) cycles++;

  aes_key_expander dut (
    .clk(clk), .rstN(rstN), .start(start), .keyLen(keyLen), .bankSel(bankSel),
    .keyValid(keyValid), .keyWord(keyWord), .busy(busy), .done(done),
    .rdBank(rdBank), .rdRound(rdRound), .rdKey(rdKey)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // S-box from the generator 3 and its inverse walk
  task automatic buildSbox();
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic modelExpand(input int len, input logic [255:0] key, input int bank);
    int nk, total;
    logic [7:0] rc;
    logic [31:0] t;
    nk = 4 + 2 * len;
    total = 4 * (nk + 7);
    rc = 8'h01;
    for (int i = 0; i < nk; i++) bm[bank][i] = key[255 - 32*i -: 32];
    for (int i = nk; i < total; i++) begin
      t = bm[bank][i-1];
      if (i % nk == 0) begin
        t = sw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end else if (nk == 8 && i % 8 == 4) begin
        t = sw(t);
      end
      bm[bank][i] = bm[bank][i-nk] ^ t;
    end
    bankLen[bank] = len;
  endtask

  task automatic readRound(input int bank, input int r, output logic [127:0] v);
    @(negedge clk);
    rdBank = 3'(bank);
    rdRound = 4'(r);
    @(negedge clk);
    v = rdKey;
  endtask

  task automatic checkBank(input int bank, input string req);
    logic [127:0] v, e;
    int rounds;
    rounds = 11 + 2 * bankLen[bank];
    for (int r = 0; r < rounds; r++) begin
      readRound(bank, r, v);
      e = {bm[bank][4*r], bm[bank][4*r+1], bm[bank][4*r+2], bm[bank][4*r+3]};
      check(v === e, $sformatf("%s bank %0d round %0d", req, bank, r), v, e);
    end
  endtask

  // gapAt: key piece index preceded by one idle clock (-1 none)
  // stray: expand-wait iteration at which a stray start is fired (-1 none)
  task automatic runKey(input int len, input logic [255:0] key, input int bank,
                        input int gapAt, input int stray);
    int nk, t0, gaps, waitIt, expBusy;
    nk = 4 + 2 * len;
    gaps = 0;
    @(negedge clk);
    start = 1'b1; keyLen = 2'(len); bankSel = 3'(bank); keyValid = 1'b0;
    t0 = cycles;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R8 busy after start", {busy, done}, 2'b10);
    for (int j = 0; j < nk / 2; j++) begin
      if (j == gapAt) begin
        keyValid = 1'b0;
        keyWord = 64'hdead_beef_0bad_f00d;
        gaps++;
        @(negedge clk);
      end
      keyValid = 1'b1;
      keyWord = key[255 - 64*j -: 64];
      @(negedge clk);
    end
    keyValid = 1'b0;
    waitIt = 0;
    while (!done && waitIt < 100) begin
      if (busy && done) check(1'b0, "R8 done while busy", 1, 0);
      if (waitIt == stray) begin
        start = 1'b1; keyLen = 2'd0; bankSel = 3'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waitIt++;
    end
    start = 1'b0;
    expBusy = 1 + nk / 2 + gaps + (4 * (nk + 7) - nk) / 2;
    check(cycles - t0 == expBusy, "R4 clocks from start to done", cycles - t0, expBusy);
    check(busy === 1'b0, "R8 idle at done", busy, 0);
    modelExpand(len, key, bank);
  endtask

  logic [255:0] k128, k192, k256, kPat;
  logic [127:0] v;

  initial begin
    buildSbox();
    k128 = {128'h2b7e1516_28aed2a6_abf71588_09cf4f3c, 128'h0};
    k192 = {192'h8e73b0f7_da0e6452_c810f32b_809079e5_62f8ead2_522c6b7b, 64'h0};
    k256 = 256'h603deb10_15ca71be_2b73aef0_857d7781_1f352c07_3b6108d7_2d9810a3_0914dff4;

    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R8 reset state", {busy, done}, 2'b00);
    rstN = 1'b1;
    @(negedge clk);

    // zero key into bank 3, used later to show a stray start is ignored
    runKey(0, 256'h0, 3, -1, -1);
    checkBank(3, "R3 zero key 128");

    runKey(0, k128, 0, -1, -1);
    checkBank(0, "R3 R5 example key 128");
    readRound(0, 10, v);
    check(v[31:0] === 32'hb6630ca6, "R3 final word 128", v[31:0], 32'hb6630ca6);

    runKey(1, k192, 1, 1, -1);
    checkBank(1, "R2 R3 example key 192 with idle key clock");
    readRound(1, 12, v);
    check(v[31:0] === 32'h01002202, "R1 final word 192", v[31:0], 32'h01002202);

    runKey(2, k256, 2, -1, 4);
    checkBank(2, "R3 example key 256");
    readRound(2, 14, v);
    check(v[31:0] === 32'h706c631e, "R1 final word 256", v[31:0], 32'h706c631e);
    checkBank(3, "R7 stray start left bank 3");

    // done holds while idle
    repeat (5) @(negedge clk);
    check(done === 1'b1, "R8 done held", done, 1);

    kPat = '1;
    runKey(2, kPat, 4, 2, -1);
    checkBank(4, "R3 all-ones key 256");
    for (int i = 0; i < 32; i++) kPat[8*i +: 8] = 8'(i * 29 + 7);
    runKey(1, kPat, 5, -1, -1);
    checkBank(5, "R3 pattern key 192");
    runKey(0, kPat, 6, 0, 7);
    checkBank(6, "R3 pattern key 128");
    runKey(2, ~kPat, 7, -1, -1);
    checkBank(7, "R3 inverted pattern key 256");

    // earlier banks intact after all later expansions
    checkBank(0, "R6 bank 0 retained");
    checkBank(1, "R6 bank 1 retained");
    checkBank(3, "R6 R7 bank 3 retained");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(ClkPeriod * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule